// File: doc/BRIEF.md
# GPIO Interrupt Summary and Status Blackout Controller

This block sits between a large bank of GPIO pin detectors and the processor. Each pin detector raises a pending flag. The block folds those flags four pins at a time into a 46-bit summary, so that an interrupt handler can find the active groups with two register reads. The block drives one shared interrupt line. After software has serviced the pending pins, it writes an end-of-interrupt bit, which re-arms that line.

The block also owns a status blackout that applies to the whole bank. When any pin's debounce configuration is rewritten and blackout is enabled, the block raises an inhibit output. All pin detectors receive it. While it is high they stop generating interrupt and wake status, and they report their interrupt-enable bits as 0. The blackout lasts a programmed number of slow-clock ticks.

Top module: `gpio_irq_summary`

## Requirements
- R1: Reading address 0 returns summary bits 0..31. Summary bit k is 1 exactly when at least one of `pend_i[4k]`, `pend_i[4k+1]`, `pend_i[4k+2]`, `pend_i[4k+3]` is 1. Reads are combinational on `bus_addr`.
- R2: Reading address 1 returns summary bits 32..45 in `bus_rdata[13:0]`. Bits 31:14 of that read are always 0.
- R3: The master register sits at address 2. Bits 11:0 hold the blackout length and bit 12 holds the blackout enable. A write to address 2 stores both fields, and a read returns them at the same positions.
- R4: Bit 13 of address 2 is the end-of-interrupt bit. Writing it as 1 is the end-of-interrupt command. It is never stored, and reads of bits 31:13 of address 2 return 0.
- R5: `irq_o` is registered. One cycle after some pin has both `pend_i` and `unmask_i` set, `irq_o` is 1. One cycle after no pin has both set, it is 0. A pending pin whose `unmask_i` is 0 never causes `irq_o`.
- R6: An end-of-interrupt write forces `irq_o` to 0 for exactly the cycle after the write edge. `irq_o` is 1 again one cycle later if an unmasked request is still present.
- R7: With blackout enabled and length L > 0, a one-cycle `dbw_i` pulse sets `inhibit_o` from the next cycle. `inhibit_o` stays 1 until the edge that takes the L-th `tick_i`, and drops right after it. It does not change in cycles without a tick.
- R8: With blackout disabled, `dbw_i` has no effect on `inhibit_o`.
- R9: A `dbw_i` pulse during an active blackout reloads the remaining count to the full length L.
- R10: After reset, the master register reads 0, and `irq_o` and `inhibit_o` are 0.
- R11: Address 3 reads as 0, and writes to it change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_addr | input | 2 | Register address (0 summary low, 1 summary high, 2 master) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pend_i | input | 184 | Pending flags from the pin detectors |
| unmask_i | input | 184 | Per-pin interrupt request unmask |
| dbw_i | input | 1 | One-cycle pulse: a debounce field of some pin was written |
| tick_i | input | 1 | Slow-clock tick, one cycle wide |
| irq_o | output | 1 | Shared interrupt request |
| inhibit_o | output | 1 | Status-generation inhibit to all pin detectors |

## Verification
The summary fold is swept with one pin pending at a time across all 184 pins. That sweep separates a wrong group index, a wrong register split and a stuck or swapped bit. It is followed by pseudo-random multi-pin patterns, which catch a fold that drops a member of a group. The interrupt path is tried with a masked pending pin, an unmasked one, an end-of-interrupt write with the request still present, and one with nothing pending. Together these separate a missing mask, a missing one-cycle gap, and a gap that does not release. The blackout is run with a short length, counted through tick by tick. It is also reloaded mid-count and triggered while disabled, so an off-by-one count, a missing reload and an ignored enable each show as a different failing check.

// File: rtl/gis_pkg.sv
package gis_pkg;
   // register addresses; fixed so that software can locate the summary halves
   typedef enum logic [1:0] {
      A_SUM_LO = 2'd0,
      A_SUM_HI = 2'd1,
      A_MASTER = 2'd2,
      A_NONE   = 2'd3
   } gis_addr_e;

   function automatic int ceil_div(input int a, input int b);
      return (a + b - 1) / b;
   endfunction
endpackage

// File: rtl/gis_group_or.sv
module gis_group_or #(
   parameter int NUM_PINS = 184,
   parameter int GROUP    = 4,
   localparam int SUM_W   = NUM_PINS / GROUP
) (
   input  logic [NUM_PINS-1:0] pend_i,
   output logic [SUM_W-1:0]    sum_o
);
   for (genvar g = 0; g < SUM_W; g++) begin : g_grp
      assign sum_o[g] = |pend_i[g*GROUP +: GROUP];
   end
endmodule

// File: rtl/gis_blackout.sv
module gis_blackout #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] len_i,
   input  logic             tick_i,
   output logic             active_o
);
   logic [CNT_W-1:0] remain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain_q <= '0;
      end else if (load_i) begin
         remain_q <= len_i;
      end else if (tick_i && (remain_q != '0)) begin
         remain_q <= remain_q - 1'b1;
      end
   end

   assign active_o = (remain_q != '0);
endmodule

// File: rtl/gis_ctrl.sv
module gis_ctrl #(
   parameter int NUM_PINS = 184,
   parameter int BLK_W    = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_master_i,
   input  logic [BLK_W+1:0] wdata_i,
   input  logic [NUM_PINS-1:0] pend_i,
   input  logic [NUM_PINS-1:0] unmask_i,
   output logic [BLK_W-1:0] len_o,
   output logic             en_o,
   output logic             irq_o
);
   localparam int EN_BIT  = BLK_W;
   localparam int EOI_BIT = BLK_W + 1;

   logic [BLK_W:0] master_q;
   logic           eoi_wr;
   logic           any_req;
   logic           irq_q;

   assign eoi_wr  = wr_master_i && wdata_i[EOI_BIT];
   assign any_req = |(pend_i & unmask_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         master_q <= '0;
      end else if (wr_master_i) begin
         master_q <= wdata_i[BLK_W:0];
      end
   end

   // the end-of-interrupt write opens a one-cycle gap in the request line
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else if (eoi_wr) begin
         irq_q <= 1'b0;
      end else begin
         irq_q <= any_req;
      end
   end

   assign len_o = master_q[BLK_W-1:0];
   assign en_o  = master_q[EN_BIT];
   assign irq_o = irq_q;
endmodule

// File: rtl/gpio_irq_summary.sv
module gpio_irq_summary #(
   parameter int NUM_PINS = 184,
   parameter int GROUP    = 4,
   parameter int REG_W    = 32,
   parameter int BLK_W    = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_we,
   input  logic [1:0]          bus_addr,
   input  logic [REG_W-1:0]    bus_wdata,
   output logic [REG_W-1:0]    bus_rdata,
   input  logic [NUM_PINS-1:0] pend_i,
   input  logic [NUM_PINS-1:0] unmask_i,
   input  logic                dbw_i,
   input  logic                tick_i,
   output logic                irq_o,
   output logic                inhibit_o
);
   import gis_pkg::*;

   localparam int SUM_W   = NUM_PINS / GROUP;
   localparam int SUM_REGS = ceil_div(SUM_W, REG_W);
   localparam int EOI_BIT = BLK_W + 1;

   // elaboration-time parameter checks
   if (NUM_PINS % GROUP != 0) begin : g_bad_group
      $error("NUM_PINS must be a multiple of GROUP");
   end
   if (SUM_REGS > 2) begin : g_bad_sum
      $error("summary must fit in two registers");
   end
   if (EOI_BIT >= REG_W) begin : g_bad_master
      $error("master fields exceed register width");
   end

   logic [SUM_W-1:0]   summary;
   logic [2*REG_W-1:0] sum_pad;
   logic [BLK_W-1:0]   blk_len;
   logic               blk_en;
   logic               wr_master;
   logic [REG_W-1:0]   master_rd;
   logic               unused_wdata;

   assign unused_wdata = ^bus_wdata[REG_W-1:EOI_BIT+1];

   gis_group_or #(.NUM_PINS(NUM_PINS), .GROUP(GROUP)) u_fold (
      .pend_i (pend_i),
      .sum_o  (summary)
   );

   always_comb begin
      sum_pad = '0;
      sum_pad[SUM_W-1:0] = summary;
   end

   assign wr_master = bus_we && (bus_addr == A_MASTER);

   gis_ctrl #(.NUM_PINS(NUM_PINS), .BLK_W(BLK_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_master_i (wr_master),
      .wdata_i     (bus_wdata[EOI_BIT:0]),
      .pend_i      (pend_i),
      .unmask_i    (unmask_i),
      .len_o       (blk_len),
      .en_o        (blk_en),
      .irq_o       (irq_o)
   );

   gis_blackout #(.CNT_W(BLK_W)) u_blk (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (dbw_i && blk_en),
      .len_i    (blk_len),
      .tick_i   (tick_i),
      .active_o (inhibit_o)
   );

   always_comb begin
      master_rd = '0;
      master_rd[BLK_W-1:0] = blk_len;
      master_rd[BLK_W]     = blk_en;
   end

   always_comb begin
      unique case (bus_addr)
         A_SUM_LO: bus_rdata = sum_pad[REG_W-1:0];
         A_SUM_HI: bus_rdata = sum_pad[2*REG_W-1:REG_W];
         A_MASTER: bus_rdata = master_rd;
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/gis_checker.sv
module gis_checker #(
   parameter int NUM_PINS = 184,
   parameter int GROUP    = 4,
   parameter int REG_W    = 32,
   parameter int BLK_W    = 12
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_we,
   input logic [1:0]          bus_addr,
   input logic [REG_W-1:0]    bus_wdata,
   input logic [REG_W-1:0]    bus_rdata,
   input logic [NUM_PINS-1:0] pend_i,
   input logic [NUM_PINS-1:0] unmask_i,
   input logic                dbw_i,
   input logic                tick_i,
   input logic                irq_o,
   input logic                inhibit_o,
   input logic                blk_en
);
   localparam int SUM_W   = NUM_PINS / GROUP;
   localparam int HI_USED = SUM_W - REG_W;
   localparam int EOI_BIT = BLK_W + 1;

   logic req_now;
   assign req_now = |(pend_i & unmask_i);

   // R5
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(req_now));

   // R6
   eoi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == 2'd2 && bus_wdata[EOI_BIT]) |=> !irq_o);

   // R7
   blk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(inhibit_o) |-> $past(dbw_i));

   // R7
   blk_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(inhibit_o) |-> $past(tick_i));

   // R8
   blk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dbw_i && !blk_en && !inhibit_o) |=> !inhibit_o);

   // R2
   hi_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 2'd1) |-> (bus_rdata[REG_W-1:HI_USED] == '0));

   // R4
   eoi_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 2'd2) |-> (bus_rdata[REG_W-1:EOI_BIT] == '0));
endmodule

bind gpio_irq_summary gis_checker #(
   .NUM_PINS (NUM_PINS),
   .GROUP    (GROUP),
   .REG_W    (REG_W),
   .BLK_W    (BLK_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pend_i    (pend_i),
   .unmask_i  (unmask_i),
   .dbw_i     (dbw_i),
   .tick_i    (tick_i),
   .irq_o     (irq_o),
   .inhibit_o (inhibit_o),
   .blk_en    (blk_en)
);

// File: tb/gpio_irq_summary_test.sv
module gpio_irq_summary_test;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 184;
   localparam int NS = 46;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_we = 1'b0;
   logic [1:0]    bus_addr = 2'd0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pend_i = '0;
   logic [NP-1:0] unmask_i = '0;
   logic          dbw_i = 1'b0;
   logic          tick_i = 1'b0;
   logic          irq_o;
   logic          inhibit_o;

   int vectors = 0;
   int misses  = 0;
   bit done    = 1'b0;
   logic [31:0] seed = 32'h1234_5678;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_irq_summary uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pend_i    (pend_i),
      .unmask_i  (unmask_i),
      .dbw_i     (dbw_i),
      .tick_i    (tick_i),
      .irq_o     (irq_o),
      .inhibit_o (inhibit_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic pulse_dbw();
      @(negedge clk); dbw_i = 1'b1;
      @(negedge clk); dbw_i = 1'b0;
   endtask

   task automatic pulse_tick();
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
   endtask

   function automatic logic [63:0] expect_sum(input logic [NP-1:0] p);
      logic [63:0] s = '0;
      for (int k = 0; k < NS; k++) s[k] = |p[4*k +: 4];
      return s;
   endfunction

   task automatic check_summary(input string tag);
      logic [31:0] lo, hi;
      logic [63:0] e;
      e = expect_sum(pend_i);
      rd(2'd0, lo);
      rd(2'd1, hi);
      check({tag, " R1 low"}, lo, e[31:0]);
      check({tag, " R2 high"}, hi, e[63:32]);
   endtask

   function automatic logic [31:0] lcg(input logic [31:0] s);
      return s * 32'd1664525 + 32'd1013904223;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         misses++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset state
      rd(2'd2, d);
      check("R10 master after reset", d, 32'h0);
      check("R10 irq after reset", {31'b0, irq_o}, 32'h0);
      check("R10 inhibit after reset", {31'b0, inhibit_o}, 32'h0);

      // R1/R2 single pin sweep
      for (int p = 0; p < NP; p++) begin
         pend_i = '0;
         pend_i[p] = 1'b1;
         check_summary("sweep");
      end

      // R1/R2 pseudo-random multi-pin patterns
      for (int n = 0; n < 40; n++) begin
         for (int w = 0; w < 6; w++) begin
            seed = lcg(seed);
            pend_i[w*32 +: 32] = (w == 5) ? {8'h0, seed[23:0]} & seed : seed & lcg(seed);
         end
         check_summary("random");
      end
      pend_i = '0;
      check_summary("empty");

      // R3/R4 master register fields
      wr(2'd2, 32'hFFFF_DABC);
      rd(2'd2, d);
      check("R3 R4 master readback", d, 32'h0000_1ABC);
      wr(2'd2, 32'h0000_0000);
      rd(2'd2, d);
      check("R3 master cleared", d, 32'h0);

      // R11 unmapped address
      wr(2'd3, 32'hFFFF_FFFF);
      rd(2'd3, d);
      check("R11 addr3 reads zero", d, 32'h0);
      rd(2'd2, d);
      check("R11 addr3 write leaves master", d, 32'h0);

      // R5 masked pending pin does not interrupt
      @(negedge clk);
      pend_i[21] = 1'b1;
      @(negedge clk);
      check("R5 masked pin", {31'b0, irq_o}, 32'h0);
      unmask_i[21] = 1'b1;
      @(negedge clk);
      check("R5 unmasked pin", {31'b0, irq_o}, 32'h1);

      // R6 end-of-interrupt gap with request still present
      wr(2'd2, 32'h0000_2000);
      check("R6 gap after eoi", {31'b0, irq_o}, 32'h0);
      @(negedge clk);
      check("R6 re-assert after gap", {31'b0, irq_o}, 32'h1);
      rd(2'd2, d);
      check("R4 eoi not stored", d, 32'h0);

      // R5 release when request clears, R6 eoi with nothing pending
      pend_i[21] = 1'b0;
      @(negedge clk);
      check("R5 release", {31'b0, irq_o}, 32'h0);
      wr(2'd2, 32'h0000_2000);
      @(negedge clk);
      check("R6 eoi idle stays low", {31'b0, irq_o}, 32'h0);
      unmask_i = '0;

      // R8 blackout disabled
      wr(2'd2, 32'h0000_0005);
      pulse_dbw();
      check("R8 disabled no inhibit", {31'b0, inhibit_o}, 32'h0);
      @(negedge clk);
      check("R8 disabled still low", {31'b0, inhibit_o}, 32'h0);

      // R7 length 3 blackout
      wr(2'd2, 32'h0000_1003);
      pulse_dbw();
      check("R7 inhibit starts", {31'b0, inhibit_o}, 32'h1);
      repeat (4) @(negedge clk);
      check("R7 holds without tick", {31'b0, inhibit_o}, 32'h1);
      pulse_tick();
      pulse_tick();
      check("R7 after two ticks", {31'b0, inhibit_o}, 32'h1);
      pulse_tick();
      check("R7 ends on third tick", {31'b0, inhibit_o}, 32'h0);

      // R9 reload mid-count
      pulse_dbw();
      pulse_tick();
      pulse_tick();
      pulse_dbw();
      pulse_tick();
      pulse_tick();
      check("R9 reload keeps inhibit", {31'b0, inhibit_o}, 32'h1);
      pulse_tick();
      check("R9 ends after full reload", {31'b0, inhibit_o}, 32'h0);

      // R7 length zero gives no blackout
      wr(2'd2, 32'h0000_1000);
      pulse_dbw();
      check("R7 zero length", {31'b0, inhibit_o}, 32'h0);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule